// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. Bit 0 is the most significant bit, and the word shows on `csr_q` so that document bit i sits on port bit 31-i. An execution-side port carries the outcome of each arithmetic operation: exception flags, the inexact (FI) and fraction-rounded (FR) indicators, and a 5-bit result-class code. Each indicator group has its own "affects" qualifier. The register gathers the sticky exception bits from this port. It sets the exception summary (FX) whenever an exception bit first goes from 0 to 1.

A software port gives four commands: a nibble-masked field write, setting or clearing a single bit, and a read-and-clear of one 4-bit field. Two summary bits are derived from the stored state and are never stored. The invalid-operation summary (VX) is the OR of the invalid detail bits. The enabled-exception summary (FEX) is the OR of each exception bit ANDed with its enable bit. FEX also drives `exc_en`, which trap logic elsewhere uses.

Field layout by document bit:
- FX=0, FEX=1, VX=2
- OX=3, UX=4, ZX=5, XX=6
- invalid details at 7..12 and 21..23
- FR=13, FI=14
- class at 15..19 (bit 15 is the class MSB)
- bit 20 reserved
- enables VE, OE, UE, ZE, XE at 24..28
- non-IEEE mode at 29
- rounding mode at 30..31

Top module: `fp_status_reg`

## Requirements
- R1: After a synchronous active-high reset, `csr_q`, `rd_field` and `exc_en` are all zero.
- R2: Document bit i of the word appears on `csr_q[31-i]`, and every command addresses bits by that numbering.
- R3: When `hw_valid` is high, each 1 in `hw_exc` at the port position of OX, UX, ZX or an invalid detail bit (document bits 7..12 and 21..23) sets that bit. Other `hw_exc` bits have no effect. Hardware never clears a sticky exception bit.
- R4: FX becomes 1 when a hardware update or a bit-set command turns an exception bit (document bits 3..12 and 21..23) from 0 to 1.
- R5: XX becomes old XX OR `hw_fi` only when `hw_fi_aff` is high, and otherwise keeps its value. FI and FR load `hw_fi` and `hw_fr` only when `hw_fi_aff` and `hw_fr_aff` are high. The class field loads `hw_cls` only when `hw_cls_aff` is high.
- R6: VX is the OR of the nine invalid detail bits. FEX is (VX&VE)|(OX&OE)|(UX&UE)|(ZX&ZE)|(XX&XE). `exc_en` equals FEX. Software writes to FEX, VX and reserved bit 20 are ignored, and bit 20 reads 0.
- R7: Field write (`sw_op`=1): for each `sw_mask[j]` that is 1, `csr_q[4j+3:4j]` takes `sw_data[4j+3:4j]`. FX is loaded from the data when its nibble is selected, and is never set implicitly by this command.
- R8: Bit set (`sw_op`=2) and bit clear (`sw_op`=3) act on document bit `sw_bit`. Set or clear of bit 0 changes FX explicitly.
- R9: Read-and-clear (`sw_op`=4) puts document bits 4f..4f+3 (f=`sw_field`) of the visible word, as it was before the command, on `rd_field` in the next cycle. It clears FX and the exception bits in that nibble and leaves the other bits. `rd_field` holds its value under every other command.
- R10: When a hardware update and a software command arrive in the same cycle, the hardware update is applied first and the software command then acts on its result. `sw_op`=0 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Execution update present this cycle |
| hw_exc | input | 32 | Exception flags in word layout |
| hw_fi | input | 1 | Inexact indicator of the operation |
| hw_fi_aff | input | 1 | Operation affects FI and XX |
| hw_fr | input | 1 | Fraction-incremented indicator |
| hw_fr_aff | input | 1 | Operation affects FR |
| hw_cls | input | 5 | Result-class code |
| hw_cls_aff | input | 1 | Operation affects the class field |
| sw_op | input | 3 | Software command: 0 none, 1 field write, 2 bit set, 3 bit clear, 4 read-and-clear |
| sw_data | input | 32 | Field-write data in word layout |
| sw_mask | input | 8 | Field-write nibble mask |
| sw_bit | input | 5 | Document bit index for set and clear |
| sw_field | input | 3 | Nibble index for read-and-clear |
| csr_q | output | 32 | Visible register word, summaries included |
| rd_field | output | 4 | Nibble returned by read-and-clear |
| exc_en | output | 1 | Enabled-exception indication (FEX) |

## Verification
The bit-set and bit-clear commands are swept over all 32 bit indices. This separates storable bits from computed and reserved ones, and exception bits, which raise FX, from control bits, which do not. Every one of the 256 field-write masks is applied with varied data, which exposes any nibble that is mis-steered or left out.

The enable set and the exception set are swept together over all 1024 pairs, with the enabled-exception result worked out arithmetically, so a wrong pairing of exception and enable shows up. Single-bit hardware pulses at every position, all sixteen combinations of FI and FR with their qualifiers, read-and-clear of every nibble, and hardware and software acting in the same cycle round out the coverage.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

    localparam int W      = 32;
    localparam int NIB    = W / 4;
    localparam int CLS_W  = 5;
    localparam int BIT_W  = $clog2(W);
    localparam int FLD_W  = $clog2(NIB);

    typedef enum logic [2:0] {
        SW_NOP      = 3'd0,
        SW_FIELD_WR = 3'd1,
        SW_BIT_SET  = 3'd2,
        SW_BIT_CLR  = 3'd3,
        SW_READ_CLR = 3'd4
    } sw_op_e;

    // document bit index (0 = MSB) to one-hot word
    function automatic logic [W-1:0] bm(int unsigned b);
        return {1'b1, {(W-1){1'b0}}} >> b;
    endfunction

    // document bit indices
    localparam int D_SUM    = 0;
    localparam int D_ENSUM  = 1;
    localparam int D_INVSUM = 2;
    localparam int D_OVF    = 3;
    localparam int D_UNF    = 4;
    localparam int D_DZ     = 5;
    localparam int D_INX    = 6;
    localparam int D_FRINC  = 13;
    localparam int D_INXCUR = 14;
    localparam int D_CLS    = 15;
    localparam int D_RSV    = 20;
    localparam int D_EN0    = 24;

    // port positions
    localparam int P_SUM    = W - 1 - D_SUM;
    localparam int P_ENSUM  = W - 1 - D_ENSUM;
    localparam int P_INVSUM = W - 1 - D_INVSUM;
    localparam int P_INX    = W - 1 - D_INX;
    localparam int P_FRINC  = W - 1 - D_FRINC;
    localparam int P_INXCUR = W - 1 - D_INXCUR;
    localparam int P_CLS_HI = W - 1 - D_CLS;
    localparam int P_RSV    = W - 1 - D_RSV;

    localparam logic [W-1:0] INV_DETAIL_MASK =
        bm(7) | bm(8) | bm(9) | bm(10) | bm(11) | bm(12) | bm(21) | bm(22) | bm(23);
    localparam logic [W-1:0] EXC_MASK =
        bm(D_OVF) | bm(D_UNF) | bm(D_DZ) | bm(D_INX) | INV_DETAIL_MASK;
    localparam logic [W-1:0] HW_EXC_MASK = EXC_MASK & ~bm(D_INX);
    localparam logic [W-1:0] RO_MASK = bm(D_ENSUM) | bm(D_INVSUM) | bm(D_RSV);

    typedef struct packed {
        logic             valid;
        logic [W-1:0]     exc;
        logic             fi;
        logic             fi_aff;
        logic             fr;
        logic             fr_aff;
        logic [CLS_W-1:0] cls;
        logic             cls_aff;
    } hw_upd_t;

    typedef struct packed {
        sw_op_e           op;
        logic [W-1:0]     data;
        logic [NIB-1:0]   mask;
        logic [BIT_W-1:0] bit_idx;
        logic [FLD_W-1:0] field;
    } sw_cmd_t;

endpackage

// File: rtl/fp_status_hw_merge.sv
module fp_status_hw_merge
    import fp_status_pkg::*;
(
    input  logic [W-1:0] state_i,
    input  hw_upd_t      upd_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] set_bits;

    always_comb begin
        state_o  = state_i;
        set_bits = '0;
        if (upd_i.valid) begin
            set_bits = upd_i.exc & HW_EXC_MASK;
            if (upd_i.fi_aff && upd_i.fi)
                set_bits = set_bits | bm(D_INX);
            state_o = state_i | set_bits;
            if ((set_bits & ~state_i) != '0)
                state_o[P_SUM] = 1'b1;
            if (upd_i.fr_aff)
                state_o[P_FRINC] = upd_i.fr;
            if (upd_i.fi_aff)
                state_o[P_INXCUR] = upd_i.fi;
            if (upd_i.cls_aff)
                state_o[P_CLS_HI -: CLS_W] = upd_i.cls;
        end
    end

    always_comb begin
        if (upd_i.valid)
            AST_HW_ONLY_SETS: assert ((state_o & state_i & EXC_MASK) == (state_i & EXC_MASK)); // R3
    end
endmodule

// File: rtl/fp_status_sw_apply.sv
module fp_status_sw_apply
    import fp_status_pkg::*;
(
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] vis_i,
    input  sw_cmd_t      cmd_i,
    output logic [W-1:0] state_o,
    output logic         rd_en_o,
    output logic [3:0]   rd_val_o
);
    logic [W-1:0] wr_en;
    logic [W-1:0] fld_m;
    logic [W-1:0] one_m;

    generate
        for (genvar j = 0; j < NIB; j++) begin : g_nib
            assign wr_en[4*j +: 4] = {4{cmd_i.mask[j]}};
            assign fld_m[W-1-4*j -: 4] = (cmd_i.field == FLD_W'(j)) ? 4'hF : 4'h0;
        end
    endgenerate

    assign one_m = bm(cmd_i.bit_idx) & ~RO_MASK;

    always_comb begin
        rd_val_o = '0;
        for (int k = 0; k < NIB; k++)
            if (cmd_i.field == FLD_W'(k))
                rd_val_o = vis_i[W-1-4*k -: 4];
    end

    always_comb begin
        logic [W-1:0] n;
        n       = base_i;
        rd_en_o = 1'b0;
        unique case (cmd_i.op)
            SW_FIELD_WR: n = (base_i & ~wr_en) | (cmd_i.data & wr_en);
            SW_BIT_SET: begin
                if ((one_m & EXC_MASK & ~base_i) != '0)
                    n[P_SUM] = 1'b1;
                n = n | one_m;
            end
            SW_BIT_CLR:  n = base_i & ~one_m;
            SW_READ_CLR: begin
                n       = base_i & ~(fld_m & (EXC_MASK | bm(D_SUM)));
                rd_en_o = 1'b1;
            end
            default:     n = base_i;
        endcase
        state_o = n & ~RO_MASK;
    end

    always_comb begin
        AST_NO_RO_STORE: assert ((state_o & RO_MASK) == '0); // R6
    end
endmodule

// File: rtl/fp_status_summary.sv
module fp_status_summary
    import fp_status_pkg::*;
(
    input  logic [W-1:0] stored_i,
    output logic [W-1:0] vis_o,
    output logic         fex_o
);
    logic [W-1:0] base;
    logic         inv_any;
    logic [4:0]   exc_v;
    logic [4:0]   en_v;

    assign base    = stored_i & ~RO_MASK;
    assign inv_any = |(base & INV_DETAIL_MASK);

    assign exc_v[0] = inv_any;
    generate
        for (genvar i = 1; i < 5; i++) begin : g_exc
            assign exc_v[i] = base[W-1-(D_OVF+i-1)];
        end
        for (genvar i = 0; i < 5; i++) begin : g_en
            assign en_v[i] = base[W-1-(D_EN0+i)];
        end
    endgenerate

    assign fex_o = |(exc_v & en_v);

    always_comb begin
        vis_o           = base;
        vis_o[P_INVSUM] = inv_any;
        vis_o[P_ENSUM]  = fex_o;
    end

    always_comb begin
        if ((stored_i & EXC_MASK) == '0)
            AST_FEX_NEEDS_EXC: assert (!fex_o); // R6
    end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
    import fp_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_valid,
    input  logic [W-1:0]     hw_exc,
    input  logic             hw_fi,
    input  logic             hw_fi_aff,
    input  logic             hw_fr,
    input  logic             hw_fr_aff,
    input  logic [CLS_W-1:0] hw_cls,
    input  logic             hw_cls_aff,
    input  logic [2:0]       sw_op,
    input  logic [W-1:0]     sw_data,
    input  logic [NIB-1:0]   sw_mask,
    input  logic [BIT_W-1:0] sw_bit,
    input  logic [FLD_W-1:0] sw_field,
    output logic [W-1:0]     csr_q,
    output logic [3:0]       rd_field,
    output logic             exc_en
);
    hw_upd_t      upd;
    sw_cmd_t      cmd;
    logic [W-1:0] stored_q;
    logic [W-1:0] after_hw;
    logic [W-1:0] after_sw;
    logic [W-1:0] vis;
    logic         fex;
    logic         rd_en;
    logic [3:0]   rd_val;
    logic [3:0]   rd_q;

    assign upd = '{valid: hw_valid, exc: hw_exc, fi: hw_fi, fi_aff: hw_fi_aff,
                   fr: hw_fr, fr_aff: hw_fr_aff, cls: hw_cls, cls_aff: hw_cls_aff};
    assign cmd = '{op: sw_op_e'(sw_op), data: sw_data, mask: sw_mask,
                   bit_idx: sw_bit, field: sw_field};

    fp_status_hw_merge u_hw (
        .state_i (stored_q),
        .upd_i   (upd),
        .state_o (after_hw)
    );

    fp_status_sw_apply u_sw (
        .base_i   (after_hw),
        .vis_i    (vis),
        .cmd_i    (cmd),
        .state_o  (after_sw),
        .rd_en_o  (rd_en),
        .rd_val_o (rd_val)
    );

    fp_status_summary u_sum (
        .stored_i (stored_q),
        .vis_o    (vis),
        .fex_o    (fex)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
            rd_q     <= '0;
        end else begin
            stored_q <= after_sw;
            if (rd_en)
                rd_q <= rd_val;
        end
    end

    assign csr_q    = vis;
    assign rd_field = rd_q;
    assign exc_en   = fex;

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sw_op == 3'd0) |=> ((csr_q & $past(csr_q) & EXC_MASK) == ($past(csr_q) & EXC_MASK))); // R3
    AST_FX_ON_NEW: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && sw_op == 3'd0 && ((hw_exc & HW_EXC_MASK & ~csr_q) != '0)) |=> csr_q[P_SUM]); // R4
    AST_XX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(hw_valid && hw_fi_aff) && sw_op == 3'd0) |=> $stable(csr_q[P_INX])); // R5
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        !csr_q[P_RSV]); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sw_op != 3'd4) |=> $stable(rd_field)); // R9
endmodule

// File: tb/fp_status_reg_bench.sv
`timescale 1ns/1ps
module fp_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_valid = 0, hw_fi = 0, hw_fi_aff = 0, hw_fr = 0, hw_fr_aff = 0, hw_cls_aff = 0;
    logic [31:0] hw_exc = '0, sw_data = '0;
    logic [4:0]  hw_cls = '0, sw_bit = '0;
    logic [2:0]  sw_op = '0, sw_field = '0;
    logic [7:0]  sw_mask = '0;
    logic [31:0] csr_q;
    logic [3:0]  rd_field;
    logic        exc_en;

    int checks = 0, bad = 0, cyc = 0;
    logic [31:0] m_st = '0;
    logic [3:0]  m_rd = '0;

    always #4 clk = ~clk;

    fp_status_reg u_fp_status_reg (
        .clk(clk), .rst(rst), .hw_valid(hw_valid), .hw_exc(hw_exc), .hw_fi(hw_fi),
        .hw_fi_aff(hw_fi_aff), .hw_fr(hw_fr), .hw_fr_aff(hw_fr_aff), .hw_cls(hw_cls),
        .hw_cls_aff(hw_cls_aff), .sw_op(sw_op), .sw_data(sw_data), .sw_mask(sw_mask),
        .sw_bit(sw_bit), .sw_field(sw_field), .csr_q(csr_q), .rd_field(rd_field), .exc_en(exc_en)
    );

    function automatic logic [31:0] b1(int b);
        return 32'h8000_0000 >> b;
    endfunction
    function automatic logic gb(logic [31:0] v, int b);
        return v[31-b];
    endfunction

    localparam logic [31:0] INVD = b1(7)|b1(8)|b1(9)|b1(10)|b1(11)|b1(12)|b1(21)|b1(22)|b1(23);
    localparam logic [31:0] EXCM = b1(3)|b1(4)|b1(5)|b1(6)|INVD;
    localparam logic [31:0] ROM  = b1(1)|b1(2)|b1(20);

    function automatic logic [31:0] vis(logic [31:0] s);
        logic [31:0] v;
        logic fx;
        v = s & ~ROM;
        if ((v & INVD) != 0) v = v | b1(2);
        fx = (gb(v,2)&gb(v,24)) | (gb(v,3)&gb(v,25)) | (gb(v,4)&gb(v,26)) |
             (gb(v,5)&gb(v,27)) | (gb(v,6)&gb(v,28));
        if (fx) v = v | b1(1);
        return v;
    endfunction

    task automatic model_step();
        logic [31:0] n, set, m, em;
        logic [31:0] v;
        n = m_st;
        if (hw_valid) begin
            set = hw_exc & EXCM & ~b1(6);
            if (hw_fi_aff && hw_fi) set = set | b1(6);
            if ((set & ~n) != 0) n = n | b1(0);
            n = n | set;
            if (hw_fr_aff) n[31-13] = hw_fr;
            if (hw_fi_aff) n[31-14] = hw_fi;
            if (hw_cls_aff) n[16:12] = hw_cls;
        end
        m = b1(sw_bit) & ~ROM;
        em = '0;
        for (int j = 0; j < 8; j++) if (sw_mask[j]) em[4*j +: 4] = 4'hF;
        case (sw_op)
            3'd1: n = (n & ~em) | (sw_data & em);
            3'd2: begin
                if ((m & EXCM & ~n) != 0) n = n | b1(0);
                n = n | m;
            end
            3'd3: n = n & ~m;
            3'd4: begin
                v = vis(m_st);
                m_rd = v[31-4*sw_field -: 4];
                em = '0;
                em[31-4*sw_field -: 4] = 4'hF;
                n = n & ~(em & (EXCM | b1(0)));
            end
            default: ;
        endcase
        m_st = n & ~ROM;
    endtask

    task automatic chk(string tag);
        logic [31:0] ev;
        ev = vis(m_st);
        checks++;
        if (csr_q !== ev || exc_en !== gb(ev,1) || rd_field !== m_rd) begin
            bad++;
            $display("FAIL %s: csr=%h en=%b rd=%h expected csr=%h en=%b rd=%h",
                     tag, csr_q, exc_en, rd_field, ev, gb(ev,1), m_rd);
        end
    endtask

    task automatic idle_inputs();
        hw_valid = 0; hw_exc = '0; hw_fi = 0; hw_fi_aff = 0; hw_fr = 0; hw_fr_aff = 0;
        hw_cls = '0; hw_cls_aff = 0; sw_op = '0; sw_data = '0; sw_mask = '0;
        sw_bit = '0; sw_field = '0;
    endtask

    // inputs already driven at a falling edge; advance one cycle and check
    task automatic go(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        chk(tag);
    endtask

    task automatic fwrite(logic [31:0] d, logic [7:0] mk, string tag);
        sw_op = 3'd1; sw_data = d; sw_mask = mk;
        go(tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset");

        // R8 / R4 / R6: set and clear every document bit index
        for (int b = 0; b < 32; b++) begin
            sw_op = 3'd2; sw_bit = 5'(b);
            go("R8 bit set");
        end
        for (int b = 0; b < 32; b++) begin
            sw_op = 3'd3; sw_bit = 5'(b);
            go("R8 bit clear");
        end
        sw_op = 3'd2; sw_bit = 5'd5;
        go("R4 set ZX raises FX");
        if (csr_q[31] !== 1'b1) begin bad++; $display("FAIL R4: FX=%b expected 1", csr_q[31]); end
        checks++;
        sw_op = 3'd3; sw_bit = 5'd0;
        go("R8 clear FX only");
        sw_op = 3'd2; sw_bit = 5'd20;
        go("R6 reserved write ignored");

        // R3 / R4: hardware pulse on each position
        for (int b = 0; b < 32; b++) begin
            fwrite(32'h0, 8'hFF, "R7 clear all");
            hw_valid = 1; hw_exc = b1(b);
            go("R3 hw exception bit");
            hw_valid = 1; hw_exc = b1(b);
            go("R4 no FX on repeat");
        end
        // R2: OX is document bit 3, port bit 28
        fwrite(32'h0, 8'hFF, "R7 clear all");
        hw_valid = 1; hw_exc = 32'h1000_0000;
        go("R2 OX position");
        checks++;
        if (csr_q !== 32'h9000_0000) begin
            bad++; $display("FAIL R2: csr=%h expected 90000000", csr_q);
        end

        // R5: every combination of FI/FR and their qualifiers
        for (int c = 0; c < 32; c++) begin
            if (c[4]) fwrite(32'h0, 8'hFF, "R7 clear all");
            hw_valid = 1; hw_fi = c[0]; hw_fi_aff = c[1]; hw_fr = c[2]; hw_fr_aff = c[3];
            hw_cls = 5'(c * 7); hw_cls_aff = c[0] ^ c[3];
            go("R5 rounding indicators");
        end

        // R7: every nibble mask
        for (int mk = 0; mk < 256; mk++) begin
            fwrite(32'hA5C3_96E1 ^ {4{8'(mk)}} ^ (32'(mk) << 13), 8'(mk), "R7 masked write");
        end
        fwrite(32'h0, 8'hFF, "R7 clear all");
        fwrite(32'h1000_0000, 8'h80, "R7 write OX without FX");
        checks++;
        if (csr_q[31] !== 1'b0) begin bad++; $display("FAIL R7: FX=%b expected 0", csr_q[31]); end

        // R6: enables x exceptions, FEX computed arithmetically
        for (int e = 0; e < 32; e++) begin
            for (int x = 0; x < 32; x++) begin
                logic [31:0] d;
                logic exp_en;
                d = '0;
                if (x[0]) d = d | b1(7);
                for (int i = 1; i < 5; i++) if (x[i]) d = d | b1(2 + i);
                for (int i = 0; i < 5; i++) if (e[i]) d = d | b1(24 + i);
                fwrite(d, 8'hFF, "R6 enable summary");
                exp_en = |(5'(e) & 5'(x));
                checks++;
                if (exc_en !== exp_en) begin
                    bad++;
                    $display("FAIL R6: exc_en=%b expected %b (e=%0d x=%0d)", exc_en, exp_en, e, x);
                end
            end
        end

        // R9: read-and-clear on each nibble
        for (int f = 0; f < 8; f++) begin
            fwrite(32'hFFFF_FFFF, 8'hFF, "R7 fill");
            sw_op = 3'd4; sw_field = 3'(f);
            go("R9 read and clear");
            sw_op = 3'd2; sw_bit = 5'd29;
            go("R9 rd_field holds");
        end

        // R10: same-cycle hardware and software
        fwrite(32'h0, 8'hFF, "R7 clear all");
        hw_valid = 1; hw_exc = b1(3); sw_op = 3'd3; sw_bit = 5'd3;
        go("R10 hw set then sw clear");
        fwrite(32'h0, 8'hFF, "R7 clear all");
        hw_valid = 1; hw_exc = b1(4); sw_op = 3'd1; sw_data = 32'h0; sw_mask = 8'h80;
        go("R10 hw then field write");
        hw_valid = 1; hw_exc = b1(9); sw_op = 3'd4; sw_field = 3'd2;
        go("R10 hw then read-clear");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule